// File: doc/BRIEF.md
# Selectable Frame-Rate Clock Divider

This block turns a telephony master clock into an 8 kHz frame strobe. It supports three master-clock rates: 2.048 MHz, which needs a divide by 256, and 1.536 MHz or 1.544 MHz, which share a base divide of 192. At 1.544 MHz each frame holds 193 master-clock cycles. The divider absorbs that extra cycle by waiting for the external frame sync instead of starting a new frame too early.

The rate is chosen by one raw select line. The line can be tied to a fixed level or driven by a toggling clock. A clock on the line is detected when at least two edges of the synchronized line fall within one frame. A clock counts the same as a high level. How that high-or-clock class maps onto a rate depends on the `VARIANT` parameter, so one design serves both device flavours. The decoded rate code changes only at a frame boundary, so the length of a frame is never altered partway through it.

Top module: `frame_clock_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `frame_strobe` is 0 and `rate_code` is 2'b10.
- R2: `frame_strobe` is high for exactly one master-clock cycle per frame.
- R3: When `rate_code` is 2'b10 (2.048 MHz), strobes come exactly 256 cycles apart, and pulses on `fsync` have no effect on that spacing.
- R4: When `rate_code` is 2'b01 (1.536/1.544 MHz) and `fsync` pulses every 192 cycles, strobes come exactly 192 cycles apart.
- R5: When `rate_code` is 2'b01 and one extra cycle passes after a frame before the next `fsync`, that frame lasts 193 cycles. This covers `fsync` every 193 cycles and also `fsync` held low.
- R6: When `rate_code` is 2'b01, a `fsync` pulse in any cycle restarts the frame, and the next strobe appears 191 cycles after the `fsync` cycle.
- R7: With `VARIANT`=0, a low select level gives `rate_code` 2'b10, and a high level or a clock gives 2'b01.
- R8: With `VARIANT`=1, a low select level gives `rate_code` 2'b01, and a high level or a clock gives 2'b10.
- R9: The select line counts as a clock only when its synchronized value shows at least two edges within one frame. A single edge counts as a level change.
- R10: `rate_code` changes only in the cycle right after a `frame_strobe`. A select change made mid-frame is still absent in the strobe cycle and takes effect one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1.536, 1.544 or 2.048 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| sel_raw | input | 1 | Raw rate select line: fixed level or toggling clock |
| fsync | input | 1 | External frame sync, one cycle wide, marks count 0 in the 192/193 rate |
| frame_strobe | output | 1 | One-cycle 8 kHz frame strobe |
| rate_code | output | 2 | Decoded rate: 2'b01 = 1.536/1.544 MHz, 2'b10 = 2.048 MHz |

## Verification
The hardest case to reach is the 193-cycle frame. It only appears when `fsync` lands one cycle after the point where a 192-cycle frame would wrap. The bench reaches it with a free-running `fsync` generator whose period can be set to 192 or 193. It lets the divider settle for a couple of frames, then measures the strobe spacing. Clock-versus-level classification is reached with a second generator that toggles the select line every few cycles. The single-edge case is reached by flipping the line once in mid-frame.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'b01,
        RATE_HIGH = 2'b10
    } rate_e;

    localparam int LOW_DIV  = 192;
    localparam int HIGH_DIV = 256;

    function automatic rate_e pick_rate(input bit variant, input logic hi_class);
        return (hi_class ^ variant) ? RATE_LOW : RATE_HIGH;
    endfunction

endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sel_classifier.sv
module sel_classifier
    import mclk_div_pkg::*;
#(
    parameter bit VARIANT   = 1'b0,
    parameter int MIN_EDGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_s,
    input  logic  frame_end,
    output rate_e rate
);
    localparam int EW = $clog2(MIN_EDGES + 1);

    logic          sel_d;
    logic          edge_seen;
    logic [EW-1:0] edge_cnt;
    logic          clk_seen;

    assign edge_seen = sel_s ^ sel_d;
    assign clk_seen  = (edge_cnt >= EW'(MIN_EDGES));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d    <= 1'b0;
            edge_cnt <= '0;
            rate     <= RATE_HIGH;
        end else begin
            sel_d <= sel_s;
            if (frame_end) begin
                edge_cnt <= '0;
                rate     <= pick_rate(VARIANT, clk_seen | sel_s);
            end else if (edge_seen && !clk_seen) begin
                edge_cnt <= edge_cnt + EW'(1);
            end
        end
    end

    // R10: rate holds outside frame boundaries
    assert_rate_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(rate));

endmodule

// File: rtl/frame_counter.sv
module frame_counter
    import mclk_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_e rate,
    input  logic  fsync,
    output logic  strobe
);
    localparam int CW = $clog2(HIGH_DIV);
    localparam logic [CW-1:0] LAST_HIGH = CW'(HIGH_DIV - 1);
    localparam logic [CW-1:0] LAST_LOW  = CW'(LOW_DIV - 1);

    logic [CW-1:0] cnt, cnt_n, last;
    logic          pad, pad_n;
    logic          low_mode;

    assign low_mode = (rate == RATE_LOW);
    assign last     = low_mode ? LAST_LOW : LAST_HIGH;
    assign strobe   = (cnt == last);

    always_comb begin
        cnt_n = cnt + CW'(1);
        pad_n = 1'b0;
        if (low_mode && fsync) begin
            cnt_n = CW'(1);
        end else if (cnt == last) begin
            cnt_n = '0;
        end else if (low_mode && cnt == '0 && !pad) begin
            cnt_n = '0;
            pad_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            pad <= 1'b0;
        end else begin
            cnt <= cnt_n;
            pad <= pad_n;
        end
    end

    // R2: strobe never lasts two cycles
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R5: at most one absorbed cycle per frame
    assert_pad_once_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && pad) |=> (cnt == CW'(1)));

    // R3: high rate counts straight through, fsync ignored
    assert_high_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (rate == RATE_HIGH && !strobe) |=> (cnt == $past(cnt) + CW'(1)));

    // R6: fsync restarts the frame in low-rate mode
    assert_fsync_realign_R6: assert property (@(posedge clk) disable iff (rst)
        (low_mode && fsync) |=> (cnt == CW'(1)));

endmodule

// File: rtl/frame_clock_divider.sv
module frame_clock_divider
    import mclk_div_pkg::*;
#(
    parameter bit VARIANT     = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_EDGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_raw,
    input  logic       fsync,
    output logic       frame_strobe,
    output logic [1:0] rate_code
);
    logic  sel_s;
    logic  strobe;
    rate_e rate;

    sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sel_raw),
        .q   (sel_s)
    );

    sel_classifier #(.VARIANT(VARIANT), .MIN_EDGES(MIN_EDGES)) u_class (
        .clk       (clk),
        .rst       (rst),
        .sel_s     (sel_s),
        .frame_end (strobe),
        .rate      (rate)
    );

    frame_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .rate   (rate),
        .fsync  (fsync),
        .strobe (strobe)
    );

    assign frame_strobe = strobe;
    assign rate_code    = rate;

    // R1: decoded code always one of the two legal values
    assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
        (rate_code == 2'b01 || rate_code == 2'b10));

endmodule

// File: tb/sim_frame_clock_divider.sv
`timescale 1ns/1ps
module sim_frame_clock_divider;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic sel_lvl = 1'b0;
    logic tg_en = 1'b0, tg_val = 1'b0;
    int   tg_cnt = 0;
    logic fs_en = 1'b0, fs_gen = 1'b0, fs_man = 1'b0;
    int   fs_per = 192;
    int   fs_cnt = 0;

    logic sel_raw, fsync;
    assign sel_raw = tg_en ? tg_val : sel_lvl;
    assign fsync   = fs_gen | fs_man;

    logic       strobe0, strobe1;
    logic [1:0] code0, code1;

    frame_clock_divider #(.VARIANT(1'b0)) u0 (
        .clk(clk), .rst(rst), .sel_raw(sel_raw), .fsync(fsync),
        .frame_strobe(strobe0), .rate_code(code0));

    frame_clock_divider #(.VARIANT(1'b1)) u1 (
        .clk(clk), .rst(rst), .sel_raw(sel_raw), .fsync(fsync),
        .frame_strobe(strobe1), .rate_code(code1));

    always @(negedge clk) begin
        if (fs_en) begin
            if (fs_cnt >= fs_per - 1) begin fs_cnt <= 0; fs_gen <= 1'b1; end
            else begin fs_cnt <= fs_cnt + 1; fs_gen <= 1'b0; end
        end else begin
            fs_cnt <= 0; fs_gen <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (tg_en) begin
            if (tg_cnt >= 2) begin tg_cnt <= 0; tg_val <= ~tg_val; end
            else tg_cnt <= tg_cnt + 1;
        end else begin
            tg_cnt <= 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        int k = 0;
        do begin @(negedge clk); k++; end while (!strobe0 && k < 1000);
        if (k >= 1000) chk("R2 strobe timeout", 0, 1);
    endtask

    // Waits for a strobe, then returns cycles to the next; also checks width (R2)
    task automatic measure(output int n);
        int k;
        wait_strobe();
        @(negedge clk);
        chk("R2 strobe width", int'(strobe0), 0);
        k = 1;
        while (!strobe0 && k < 1000) begin @(negedge clk); k++; end
        n = k;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 strobe in reset", int'(strobe0), 0);
        chk("R1 code in reset", int'(code0), 2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe after reset", int'(strobe0), 0);
        chk("R1 code after reset", int'(code0), 2);
    endtask

    task automatic t_high_rate();
        int n;
        sel_lvl = 1'b0; fs_per = 100; fs_en = 1'b1;
        repeat (2) wait_strobe();
        measure(n);
        chk("R3 period 256 with fsync noise", n, 256);
        chk("R7 low level gives 2.048", int'(code0), 2);
    endtask

    task automatic t_low_192();
        int n;
        sel_lvl = 1'b1; fs_per = 192;
        repeat (3) wait_strobe();
        chk("R7 high level gives 1.536/1.544", int'(code0), 1);
        measure(n);
        chk("R4 period 192", n, 192);
    endtask

    task automatic t_low_193();
        int n;
        fs_per = 193;
        repeat (2) wait_strobe();
        measure(n);
        chk("R5 period 193 with fsync", n, 193);
        fs_en = 1'b0;
        repeat (2) wait_strobe();
        measure(n);
        chk("R5 period 193 without fsync", n, 193);
    endtask

    task automatic t_realign();
        int k;
        wait_strobe();
        repeat (50) @(negedge clk);
        fs_man = 1'b1;
        @(negedge clk);
        fs_man = 1'b0;
        k = 1;
        while (!strobe0 && k < 400) begin @(negedge clk); k++; end
        chk("R6 strobe after fsync", k, 191);
    endtask

    task automatic t_clock_sel();
        int n;
        sel_lvl = 1'b0; fs_per = 192; fs_en = 1'b1;
        repeat (3) wait_strobe();
        chk("R7 back to 2.048 on low", int'(code0), 2);
        tg_en = 1'b1;
        repeat (3) wait_strobe();
        chk("R9 toggling select is a clock", int'(code0), 1);
        measure(n);
        chk("R4 period 192 with clock select", n, 192);
        tg_en = 1'b0;
        repeat (3) wait_strobe();
        chk("R9 stopped clock at low level", int'(code0), 2);
    endtask

    task automatic t_boundary();
        sel_lvl = 1'b0;
        wait_strobe();
        repeat (20) @(negedge clk);
        sel_lvl = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 no mid-frame change", int'(code0), 2);
        wait_strobe();
        chk("R10 unchanged in strobe cycle", int'(code0), 2);
        @(negedge clk);
        chk("R10 changed after strobe", int'(code0), 1);
        repeat (20) @(negedge clk);
        sel_lvl = 1'b0;
        wait_strobe();
        @(negedge clk);
        chk("R9 single edge is a level", int'(code0), 2);
    endtask

    task automatic t_variant1();
        sel_lvl = 1'b0; tg_en = 1'b0;
        repeat (700) @(negedge clk);
        chk("R8 low level gives 1.536/1.544", int'(code1), 1);
        sel_lvl = 1'b1;
        repeat (700) @(negedge clk);
        chk("R8 high level gives 2.048", int'(code1), 2);
        sel_lvl = 1'b0; tg_en = 1'b1;
        repeat (700) @(negedge clk);
        chk("R8 clock gives 2.048", int'(code1), 2);
        tg_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_high_rate();
        t_low_192();
        t_low_193();
        t_realign();
        t_clock_sel();
        t_boundary();
        t_variant1();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule